// File: doc/BRIEF.md
# Flash Self-Programming Command Controller

This block gates flash self-programming requests from a CPU. Software first writes a command pattern into an 8-bit control register. It then issues a separate program strobe. The command runs only if the strobe comes within a short arming window after that write. Three commands exist: a page write, a lock-bit write, and a re-enable that releases the application region for reading again. The flash array is outside the block. A page write starts it with a one-cycle start pulse and a page number, and the array ends the operation with a done pulse.

Flash is split into two regions at a page boundary given by a parameter. Pages below the boundary belong to the application region, which can be blocked while the rest of flash stays readable. When a page write targets that region, the block sets a sticky busy flag, and reads of the region stay blocked until software clears the flag. Pages at or above the boundary belong to the boot region. A page write there instead asks the CPU to halt until the operation is done. A lock-bit write only ever clears bits in a 4-bit lock field. When its enable bit is set, the ready interrupt is a level that stays high whenever no command is pending.

Top module: `flashProgCtl`

## Requirements
- R1: After reset the control readback is 0x00, the lock field is 4'hF, and start, halt, read block and interrupt are all low.
- R2: Control pattern 0x05 arms a page write; bit 7 is the interrupt enable and does not take part in the match. An accepted strobe gives a one-cycle flashStart in the next cycle, with flashPage equal to addrPtr[ADDR_W-1:PAGE_OFS_W]. The data operand is ignored.
- R3: A strobe is accepted only on the 1st to 4th clock edge after the control write edge. On the 4th edge with no strobe, the command bits clear to zero. A later strobe starts nothing.
- R4: A page write to a page below BOOT_FIRST_PAGE sets the busy flag (readback bit 6) and appReadBlock from the cycle after the strobe, and does not halt the CPU.
- R5: A page write to a page at or above BOOT_FIRST_PAGE raises cpuHalt from the cycle after the strobe up to the flashDone edge, and does not set the busy flag.
- R6: A flashDone pulse during a page write clears readback bits 4:0 to zero.
- R7: The busy flag and appReadBlock stay set after completion. They clear only when pattern 0x11 is written and then accepted by a strobe.
- R8: While a page write is in progress, a control write changes only bit 7. A re-enable written then, and followed by a strobe, leaves the busy flag and the command bits unchanged.
- R9: readyIrq equals interrupt enable AND NOT readback bit 0, held as a level for as long as that holds.
- R10: Pattern 0x09 with an accepted strobe replaces the lock field with its old value AND dataOp[5:2]. It ignores addrPtr, raises neither cpuHalt nor appReadBlock, gives no flashStart, and clears the command bits.
- R11: A lock bit at 0 never returns to 1.
- R12: A control write whose bits 5:0 match none of 0x05, 0x09 or 0x11 loads only the interrupt enable and arms nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlWrEn | input | 1 | Control register write enable |
| ctlWrData | input | 8 | Control write data: bit 7 irq enable, bits 5:0 command |
| ctlRdData | output | 8 | Readback: {irqEn, busy, 0, cmd[4:0]} |
| progStrobe | input | 1 | Program strobe that executes an armed command |
| addrPtr | input | ADDR_W | Byte address pointer, page field in the upper bits |
| dataOp | input | 8 | Data operand, bits 5:2 used for lock writes |
| flashStart | output | 1 | One-cycle start of a page write |
| flashPage | output | ADDR_W-PAGE_OFS_W | Page number of the current page write |
| flashDone | input | 1 | Flash array finished the page write |
| cpuHalt | output | 1 | CPU halt request during a boot-region write |
| appReadBlock | output | 1 | Reads of the application region are blocked |
| readyIrq | output | 1 | Level ready interrupt |
| lockBits | output | 4 | Lock field, 0 means programmed |

## Verification
Two events can land in the same cycle: the end of the arming window and a strobe arriving, and a control write arriving during a page write that is still running. The bench walks a strobe to the 4th and then the 5th edge after the control write and judges whether flashStart or cpuHalt follows. Separately, it writes and strobes the re-enable pattern while a page write is still running. It checks that the busy flag, the read block and the readback command bits are unchanged before the done pulse, and that a re-enable issued after completion does clear them.

// File: rtl/flashProgPkg.sv
package flashProgPkg;

  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_PAGE,
    CMD_LOCK,
    CMD_REEN
  } cmdKind_t;

  typedef struct packed {
    logic ctlLoad;     // load interrupt enable from write data
    logic cmdLoad;     // load command bits from write data
    logic cmdClear;    // clear command bits
    logic pageLaunch;  // capture page number for the array
    logic lockLoad;    // merge new lock bits
    logic busySet;     // application region becomes busy
    logic busyClear;   // application region released
  } ctlStrobes_t;

  localparam logic [5:0] PAT_PAGE = 6'b000101;
  localparam logic [5:0] PAT_LOCK = 6'b001001;
  localparam logic [5:0] PAT_REEN = 6'b010001;

  function automatic cmdKind_t decodeCmd(input logic [5:0] bits);
    cmdKind_t kind;
    case (bits)
      PAT_PAGE: kind = CMD_PAGE;
      PAT_LOCK: kind = CMD_LOCK;
      PAT_REEN: kind = CMD_REEN;
      default:  kind = CMD_NONE;
    endcase
    return kind;
  endfunction

endpackage

// File: rtl/flashProgCtlSeq.sv
module flashProgCtlSeq
  import flashProgPkg::*;
#(
  parameter int WINDOW          = 4,
  parameter int PAGE_W          = 9,
  parameter int BOOT_FIRST_PAGE = 448
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlWrEn,
  input  logic [7:0]        ctlWrData,
  input  logic              progStrobe,
  input  logic [PAGE_W-1:0] pageIdx,
  input  logic              flashDone,
  output ctlStrobes_t       stb,
  output logic              opActive,
  output logic              cpuHalt,
  output logic              flashStart
);

  localparam int CNT_W = $clog2(WINDOW + 1);
  localparam logic [PAGE_W-1:0] BOOT_PAGE = PAGE_W'(BOOT_FIRST_PAGE);

  cmdKind_t   armedKind;
  cmdKind_t   wrKind;
  logic [CNT_W-1:0] winCnt;
  logic       armed;
  logic       fire;
  logic       expire;
  logic       toApp;
  logic       unusedWrBits;

  assign unusedWrBits = ^ctlWrData[7:6];

  assign armed  = (armedKind != CMD_NONE);
  assign wrKind = decodeCmd(ctlWrData[5:0]);
  assign fire   = armed && progStrobe;
  assign expire = armed && !progStrobe && (winCnt == CNT_W'(1));
  assign toApp  = (pageIdx < BOOT_PAGE);

  always_comb begin
    stb = '0;
    stb.ctlLoad = ctlWrEn;
    if (ctlWrEn && !opActive && !fire && (wrKind != CMD_NONE))
      stb.cmdLoad = 1'b1;
    if (fire) begin
      case (armedKind)
        CMD_PAGE: begin
          stb.pageLaunch = 1'b1;
          stb.busySet    = toApp;
        end
        CMD_LOCK: begin
          stb.lockLoad = 1'b1;
          stb.cmdClear = 1'b1;
        end
        CMD_REEN: begin
          stb.busyClear = 1'b1;
          stb.cmdClear  = 1'b1;
        end
        default: ;
      endcase
    end
    if (expire)
      stb.cmdClear = 1'b1;
    if (opActive && flashDone)
      stb.cmdClear = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armedKind  <= CMD_NONE;
      winCnt     <= '0;
      opActive   <= 1'b0;
      cpuHalt    <= 1'b0;
      flashStart <= 1'b0;
    end else begin
      flashStart <= stb.pageLaunch;
      if (stb.cmdLoad) begin
        armedKind <= wrKind;
        winCnt    <= CNT_W'(WINDOW);
      end else if (fire || expire) begin
        armedKind <= CMD_NONE;
        winCnt    <= '0;
      end else if (armed) begin
        winCnt <= winCnt - 1'b1;
      end
      if (stb.pageLaunch) begin
        opActive <= 1'b1;
        cpuHalt  <= !toApp;
      end else if (opActive && flashDone) begin
        opActive <= 1'b0;
        cpuHalt  <= 1'b0;
      end
    end
  end

  AST_HALT_WITHIN_OP: assert property (@(posedge clk) disable iff (!rstN)
    cpuHalt |-> opActive);  // R5

  AST_START_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    flashStart |-> $past(progStrobe));  // R3

  AST_REEN_IGNORED_IN_OP: assert property (@(posedge clk) disable iff (!rstN)
    opActive |-> !stb.busyClear);  // R8

  AST_LOCK_NO_HALT: assert property (@(posedge clk) disable iff (!rstN)
    stb.lockLoad |=> !cpuHalt && !flashStart);  // R10

endmodule

// File: rtl/flashProgCtlPath.sv
module flashProgCtlPath
  import flashProgPkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int PAGE_OFS_W = 7
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctlStrobes_t              stb,
  input  logic [7:0]               ctlWrData,
  input  logic [ADDR_W-1:0]        addrPtr,
  input  logic [7:0]               dataOp,
  output logic [ADDR_W-PAGE_OFS_W-1:0] pageIdx,
  output logic [ADDR_W-PAGE_OFS_W-1:0] flashPage,
  output logic [7:0]               ctlRdData,
  output logic                     appReadBlock,
  output logic                     readyIrq,
  output logic [3:0]               lockBits
);

  localparam int PAGE_W = ADDR_W - PAGE_OFS_W;

  logic       irqEn;
  logic [4:0] cmdBits;
  logic       appBusy;
  logic       unusedBits;

  assign unusedBits = ^{ctlWrData[6:5], dataOp[7:6], dataOp[1:0], addrPtr[PAGE_OFS_W-1:0]};

  assign pageIdx      = addrPtr[ADDR_W-1:PAGE_OFS_W];
  assign ctlRdData    = {irqEn, appBusy, 1'b0, cmdBits};
  assign appReadBlock = appBusy;
  assign readyIrq     = irqEn && !cmdBits[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqEn     <= 1'b0;
      cmdBits   <= '0;
      appBusy   <= 1'b0;
      lockBits  <= 4'hF;
      flashPage <= '0;
    end else begin
      if (stb.ctlLoad)
        irqEn <= ctlWrData[7];
      if (stb.cmdLoad)
        cmdBits <= ctlWrData[4:0];
      else if (stb.cmdClear)
        cmdBits <= '0;
      if (stb.busySet)
        appBusy <= 1'b1;
      else if (stb.busyClear)
        appBusy <= 1'b0;
      if (stb.lockLoad)
        lockBits <= lockBits & dataOp[5:2];
      if (stb.pageLaunch)
        flashPage <= PAGE_W'(pageIdx);
    end
  end

  AST_LOCK_NEVER_RISES: assert property (@(posedge clk) disable iff (!rstN)
    (lockBits & ~$past(lockBits)) == 4'h0);  // R11

  AST_BUSY_FALLS_ON_REEN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(appBusy) |-> $past(stb.busyClear));  // R7

endmodule

// File: rtl/flashProgCtl.sv
module flashProgCtl
  import flashProgPkg::*;
#(
  parameter int ADDR_W          = 16,
  parameter int PAGE_OFS_W      = 7,
  parameter int WINDOW          = 4,
  parameter int BOOT_FIRST_PAGE = 448
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         ctlWrEn,
  input  logic [7:0]                   ctlWrData,
  output logic [7:0]                   ctlRdData,
  input  logic                         progStrobe,
  input  logic [ADDR_W-1:0]            addrPtr,
  input  logic [7:0]                   dataOp,
  output logic                         flashStart,
  output logic [ADDR_W-PAGE_OFS_W-1:0] flashPage,
  input  logic                         flashDone,
  output logic                         cpuHalt,
  output logic                         appReadBlock,
  output logic                         readyIrq,
  output logic [3:0]                   lockBits
);

  localparam int PAGE_W = ADDR_W - PAGE_OFS_W;

  ctlStrobes_t       stb;
  logic [PAGE_W-1:0] pageIdx;
  logic              opActive;

  flashProgCtlSeq #(
    .WINDOW(WINDOW), .PAGE_W(PAGE_W), .BOOT_FIRST_PAGE(BOOT_FIRST_PAGE)
  ) seq (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .progStrobe(progStrobe), .pageIdx(pageIdx), .flashDone(flashDone),
    .stb(stb), .opActive(opActive), .cpuHalt(cpuHalt), .flashStart(flashStart)
  );

  flashProgCtlPath #(
    .ADDR_W(ADDR_W), .PAGE_OFS_W(PAGE_OFS_W)
  ) path (
    .clk(clk), .rstN(rstN), .stb(stb), .ctlWrData(ctlWrData),
    .addrPtr(addrPtr), .dataOp(dataOp), .pageIdx(pageIdx),
    .flashPage(flashPage), .ctlRdData(ctlRdData),
    .appReadBlock(appReadBlock), .readyIrq(readyIrq), .lockBits(lockBits)
  );

  AST_BLOCK_NOT_WITH_HALT_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuHalt) |-> !$rose(appReadBlock));  // R5

endmodule

// File: tb/flashProgCtl_test.sv
`timescale 1ns/1ps
module flashProgCtl_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctlWrEn = 1'b0;
  logic [7:0]  ctlWrData = '0;
  logic [7:0]  ctlRdData;
  logic        progStrobe = 1'b0;
  logic [15:0] addrPtr = '0;
  logic [7:0]  dataOp = '0;
  logic        flashStart;
  logic [8:0]  flashPage;
  logic        flashDone = 1'b0;
  logic        cpuHalt;
  logic        appReadBlock;
  logic        readyIrq;
  logic [3:0]  lockBits;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  flashProgCtl uut (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .ctlRdData(ctlRdData), .progStrobe(progStrobe), .addrPtr(addrPtr),
    .dataOp(dataOp), .flashStart(flashStart), .flashPage(flashPage),
    .flashDone(flashDone), .cpuHalt(cpuHalt), .appReadBlock(appReadBlock),
    .readyIrq(readyIrq), .lockBits(lockBits)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles == 20000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<20000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ctlWrite(input logic [7:0] d);
    @(negedge clk); ctlWrEn = 1'b1; ctlWrData = d;
    @(negedge clk); ctlWrEn = 1'b0;
  endtask

  task automatic strobeAfter(input int d, input logic [15:0] a, input logic [7:0] dat);
    repeat (d - 1) @(negedge clk);
    progStrobe = 1'b1; addrPtr = a; dataOp = dat;
    @(negedge clk); progStrobe = 1'b0;
  endtask

  task automatic pulseDone();
    flashDone = 1'b1;
    @(negedge clk); flashDone = 1'b0;
  endtask

  task automatic tReset();
    chk("R1 readback", ctlRdData, 8'h00);
    chk("R1 lock", lockBits, 4'hF);
    chk("R1 outputs", {flashStart, cpuHalt, appReadBlock, readyIrq}, 4'h0);
  endtask

  task automatic tUnknown();
    ctlWrite(8'h87);
    chk("R12 only irq enable", ctlRdData, 8'h80);
    chk("R9 irq when idle", readyIrq, 1'b1);
    strobeAfter(1, 16'h1280, 8'h00);
    chk("R12 no start", {flashStart, appReadBlock, cpuHalt}, 3'b000);
    ctlWrite(8'h00);
    chk("R9 irq off", readyIrq, 1'b0);
  endtask

  task automatic tWindow();
    ctlWrite(8'h05);
    repeat (3) @(negedge clk);
    chk("R3 armed at 3rd edge", ctlRdData, 8'h05);
    @(negedge clk);
    chk("R3 cleared at 4th edge", ctlRdData, 8'h00);
    strobeAfter(1, 16'hE100, 8'h00);
    chk("R3 late strobe ignored", {flashStart, cpuHalt, appReadBlock}, 3'b000);
  endtask

  task automatic tBoot();
    ctlWrite(8'h05);
    strobeAfter(4, 16'hE100, 8'h00);
    chk("R3 strobe at 4th edge / R5 halt", cpuHalt, 1'b1);
    chk("R2 start", flashStart, 1'b1);
    chk("R2 page", flashPage, 9'd450);
    chk("R5 no busy", {appReadBlock, ctlRdData[6]}, 2'b00);
    repeat (2) @(negedge clk);
    chk("R5 halt held", cpuHalt, 1'b1);
    pulseDone();
    chk("R5 halt released", cpuHalt, 1'b0);
    chk("R6 cmd cleared", ctlRdData, 8'h00);
  endtask

  task automatic tApp();
    ctlWrite(8'h85);
    chk("R9 irq low while pending", readyIrq, 1'b0);
    strobeAfter(2, 16'h1295, 8'h3C);
    chk("R2 start", flashStart, 1'b1);
    chk("R2 page", flashPage, 9'd37);
    chk("R4 read block", appReadBlock, 1'b1);
    chk("R4 busy bit", ctlRdData[6], 1'b1);
    chk("R4 no halt", cpuHalt, 1'b0);
    @(negedge clk);
    chk("R2 start one cycle", flashStart, 1'b0);
    ctlWrite(8'h91);
    strobeAfter(1, 16'h0000, 8'h00);
    chk("R8 reen ignored in op", ctlRdData, 8'hC5);
    chk("R8 block kept", appReadBlock, 1'b1);
    pulseDone();
    chk("R6 done clears cmd", ctlRdData, 8'hC0);
    chk("R9 irq after done", readyIrq, 1'b1);
    repeat (3) @(negedge clk);
    chk("R9 irq level held", readyIrq, 1'b1);
    chk("R7 busy sticky", appReadBlock, 1'b1);
    ctlWrite(8'h91);
    strobeAfter(1, 16'h0000, 8'h00);
    chk("R7 busy released", appReadBlock, 1'b0);
    chk("R7 readback", ctlRdData, 8'h80);
    ctlWrite(8'h00);
  endtask

  task automatic tLock();
    ctlWrite(8'h09);
    strobeAfter(1, 16'hE100, 8'hF3);
    chk("R10 lock merge", lockBits, 4'hC);
    chk("R10 no halt/block/start", {cpuHalt, appReadBlock, flashStart}, 3'b000);
    chk("R10 cmd cleared", ctlRdData, 8'h00);
    ctlWrite(8'h09);
    strobeAfter(1, 16'h0000, 8'hFF);
    chk("R11 no return to 1", lockBits, 4'hC);
    ctlWrite(8'h09);
    strobeAfter(3, 16'h0000, 8'hEB);
    chk("R11 and merge", lockBits, 4'h8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tUnknown();
    tWindow();
    tBoot();
    tApp();
    tLock();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule